// File: doc/BRIEF.md
# Rotating Character Word Display

This block places a short word on a row of seven-segment digits and turns it around the row like a ring. The word is five 3-bit character codes packed into one 15-bit input. A 3-bit rotation select picks how far the word has turned. A mode bit chooses between two arrangements. In the five-digit arrangement the word fills the rightmost five digits and the three left digits stay dark. In the eight-digit arrangement the word and three blank positions form an eight-place ring that fills the whole row.

Every digit goes through a small decoder. It shows H, E, L or O, and it shows a dark digit for every other code. The block holds no state: the segment outputs follow the inputs directly. Internally, a routing controller turns the mode and select into one small strobe record per digit, which names the word character the digit shows or marks the digit blank. A datapath gathers the chosen code for each digit and decodes it.

Top module: `wordRotDisplay`

## Requirements
- R1: Segment outputs are active low, and bit i of a digit's 7-bit value drives segment i. Code 000 gives H = 7'b0001001, code 001 gives E = 7'b0000110, code 010 gives L = 7'b1000111 and code 011 gives O = 7'b1000000 (written bit 6 down to bit 0).
- R2: Codes 100, 101, 110 and 111 each give a dark digit, 7'b1111111.
- R3: Word character k (k = 0..4) is codeWord[14-3k:12-3k]. With wideMode = 0 and select s from 0 to 4, digit d (d = 4..0, digit 4 leftmost of the five) shows character (4 - d + s) mod 5. For HELLO, select 0 shows H E L L O and select 4 shows O H E L L.
- R4: With wideMode = 0, select values 5, 6 and 7 give exactly the same output as select 4.
- R5: With wideMode = 0, digits 7, 6 and 5 are always dark.
- R6: With wideMode = 1 the ring is three blanks followed by characters 0..4. Display position q (q = 0 for digit 7, q = 7 for digit 0) shows ring entry (q + s) mod 8. Select 0 puts the word in digits 4..0, and select 3 puts it in digits 7..3.
- R7: With wideMode = 1 and select 4 to 7, the word wraps around. For HELLO, select 4 shows E L L O, three blanks, then H on digit 0.
- R8: The block is combinational. A change on any input shows on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| codeWord | input | 15 | Five 3-bit character codes; bits 14:12 hold the first character |
| rotSel | input | 3 | Rotation amount |
| wideMode | input | 1 | 0 = five-digit row, 1 = eight-digit ring |
| segOut | output | 8x7 | Active-low segments per digit; segOut[7] is leftmost |

## Verification
The hardest case to reach is the eight-digit wrap, where the word is split across both ends of the row. A second hard case is the saturated selects 5 to 7 in five-digit mode, which must match select 4 exactly. Both show up only when the select sweeps its whole range in each mode. To tell misrouted characters apart, the stimulus uses words with distinct codes in every position, and other words that mix blank codes into the word. A queue-based ring model in the bench rotates the word one step at a time and predicts every digit of every vector.

// File: rtl/wordrot_pkg.sv
package wordrot_pkg;
  localparam int CHAR_W   = 3;
  localparam int WORD_LEN = 5;
  localparam int RING_LEN = 8;
  localparam int SEG_W    = 7;
  localparam int SEL_W    = $clog2(RING_LEN);
  localparam int PAD_LEN  = RING_LEN - WORD_LEN;
  localparam int CODE_W   = CHAR_W * WORD_LEN;

  localparam logic [CHAR_W-1:0] BLANK_CODE = '1;

  localparam logic [SEG_W-1:0] SEG_H     = 7'b0001001;
  localparam logic [SEG_W-1:0] SEG_E     = 7'b0000110;
  localparam logic [SEG_W-1:0] SEG_L     = 7'b1000111;
  localparam logic [SEG_W-1:0] SEG_O     = 7'b1000000;
  localparam logic [SEG_W-1:0] SEG_BLANK = '1;

  // Strobes from control to datapath for one digit
  typedef struct packed {
    logic [WORD_LEN-1:0] pick;   // bit k: show word character k
    logic                blank;  // show a dark digit
  } digitRoute_t;

  typedef digitRoute_t [RING_LEN-1:0] routeSet_t;
endpackage

// File: rtl/glyphDecode.sv
module glyphDecode
  import wordrot_pkg::*;
(
  input  logic [CHAR_W-1:0] charCode,
  output logic [SEG_W-1:0]  segBits
);
  always_comb begin
    case (charCode)
      3'd0:    segBits = SEG_H;
      3'd1:    segBits = SEG_E;
      3'd2:    segBits = SEG_L;
      3'd3:    segBits = SEG_O;
      default: segBits = SEG_BLANK;
    endcase
  end
endmodule

// File: rtl/rotRouteCtrl.sv
module rotRouteCtrl
  import wordrot_pkg::*;
(
  input  logic [SEL_W-1:0] rotSel,
  input  logic             wideMode,
  output routeSet_t        routes
);
  logic [RING_LEN-1:0] blankVec;
  logic [WORD_LEN-1:0][RING_LEN-1:0] charCol;

  for (genvar d = 0; d < RING_LEN; d++) begin : g_digit
    localparam int POS_WIDE = RING_LEN - 1 - d;
    int wideSrc;
    int narrowSrc;
    int rotAmt;

    always_comb begin
      wideSrc = (POS_WIDE + int'(rotSel)) % RING_LEN;
      rotAmt  = (int'(rotSel) >= WORD_LEN - 1) ? WORD_LEN - 1 : int'(rotSel);
      narrowSrc = 0;
      if (d < WORD_LEN) narrowSrc = (WORD_LEN - 1 - d + rotAmt) % WORD_LEN;
    end

    if (d < WORD_LEN) begin : g_inword
      always_comb begin
        routes[d] = '0;
        if (wideMode) begin
          if (wideSrc < PAD_LEN) routes[d].blank = 1'b1;
          else routes[d].pick = WORD_LEN'(1) << (wideSrc - PAD_LEN);
        end else begin
          routes[d].pick = WORD_LEN'(1) << narrowSrc;
        end
      end
    end else begin : g_padonly
      always_comb begin
        routes[d] = '0;
        if (wideMode && wideSrc >= PAD_LEN)
          routes[d].pick = WORD_LEN'(1) << (wideSrc - PAD_LEN);
        else
          routes[d].blank = 1'b1;
      end
    end

    assign blankVec[d] = routes[d].blank;
    for (genvar k = 0; k < WORD_LEN; k++) begin : g_col
      assign charCol[k][d] = routes[d].pick[k];
    end
  end

  // R5
  always_comb begin
    pad_count_chk: assert ($countones(blankVec) == PAD_LEN)
      else $error("blank digit count wrong");
  end

  // R6
  for (genvar k = 0; k < WORD_LEN; k++) begin : g_once
    always_comb begin
      char_once_chk: assert ($countones(charCol[k]) == 1)
        else $error("word character %0d not shown exactly once", k);
    end
  end
endmodule

// File: rtl/wordRotDatapath.sv
module wordRotDatapath
  import wordrot_pkg::*;
(
  input  logic [CODE_W-1:0]               codeWord,
  input  routeSet_t                       routes,
  output logic [RING_LEN-1:0][SEG_W-1:0]  segOut
);
  function automatic logic [CHAR_W-1:0] gatherCode(
    input logic [CODE_W-1:0]   word,
    input logic [WORD_LEN-1:0] pick,
    input logic                blank
  );
    logic [CHAR_W-1:0]   acc;
    logic [CODE_W-1:0]   wr;
    logic [WORD_LEN-1:0] pr;
    acc = blank ? BLANK_CODE : '0;
    wr  = word;
    pr  = pick;
    for (int k = 0; k < WORD_LEN; k++) begin
      if (pr[0]) acc = acc | wr[CODE_W-1 -: CHAR_W];
      wr = wr << CHAR_W;
      pr = pr >> 1;
    end
    return acc;
  endfunction

  for (genvar d = 0; d < RING_LEN; d++) begin : g_digit
    logic [CHAR_W-1:0] digitCode;

    assign digitCode = gatherCode(codeWord, routes[d].pick, routes[d].blank);

    glyphDecode u_glyph (
      .charCode (digitCode),
      .segBits  (segOut[d])
    );

    // R3
    always_comb begin
      route_onehot_chk: assert ($countones({routes[d].pick, routes[d].blank}) == 1)
        else $error("digit %0d route not one-hot", d);
    end

    // R2
    always_comb begin
      blank_dark_chk: assert (!routes[d].blank || segOut[d] == SEG_BLANK)
        else $error("digit %0d blank route lit segments", d);
    end
  end
endmodule

// File: rtl/wordRotDisplay.sv
module wordRotDisplay
  import wordrot_pkg::*;
(
  input  logic [14:0]      codeWord,
  input  logic [2:0]       rotSel,
  input  logic             wideMode,
  output logic [7:0][6:0]  segOut
);
  routeSet_t routes;

  rotRouteCtrl u_ctrl (
    .rotSel   (rotSel),
    .wideMode (wideMode),
    .routes   (routes)
  );

  wordRotDatapath u_dp (
    .codeWord (codeWord),
    .routes   (routes),
    .segOut   (segOut)
  );
endmodule

// File: tb/wordRotDisplay_tb_top.sv
module wordRotDisplay_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [14:0]     codeWord = '0;
  logic [2:0]      rotSel = '0;
  logic            wideMode = 1'b0;
  logic [7:0][6:0] segOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  wordRotDisplay dut_i (
    .codeWord (codeWord),
    .rotSel   (rotSel),
    .wideMode (wideMode),
    .segOut   (segOut)
  );

  function automatic logic [6:0] glyphRef(int c);
    case (c)
      0: return 7'b0001001;
      1: return 7'b0000110;
      2: return 7'b1000111;
      3: return 7'b1000000;
      default: return 7'b1111111;
    endcase
  endfunction

  // Expected code for display positions 0..7 (left to right)
  function automatic int refCode(logic [14:0] w, int sel, bit wide, int pos);
    int q[$];
    int rot;
    int disp[$];
    for (int k = 0; k < 5; k++) q.push_back(int'(w[14-3*k -: 3]));
    if (wide) begin
      for (int k = 0; k < 3; k++) q.push_front(7);
      repeat (sel) q.push_back(q.pop_front());
      disp = q;
    end else begin
      rot = (sel > 4) ? 4 : sel;
      repeat (rot) q.push_back(q.pop_front());
      disp = {7, 7, 7};
      foreach (q[i]) disp.push_back(q[i]);
    end
    return disp[pos];
  endfunction

  task automatic checkDigit(int d, logic [6:0] exp, string tag);
    checks++;
    if (segOut[d] !== exp) begin
      failures++;
      $display("FAIL %s digit %0d sel=%0d wide=%0d word=%h: got %b expected %b",
               tag, d, rotSel, wideMode, codeWord, segOut[d], exp);
    end
  endtask

  task automatic checkAll();
    string tag;
    for (int d = 0; d < 8; d++) begin
      if (!wideMode) tag = (d >= 5) ? "R5" : (rotSel > 3'd4) ? "R4" : "R3";
      else           tag = (rotSel >= 3'd4) ? "R7" : "R6";
      checkDigit(d, glyphRef(refCode(codeWord, int'(rotSel), wideMode, 7 - d)), tag);
    end
  endtask

  task automatic applyVec(logic [14:0] w, int sel, bit wide);
    @(negedge clk);
    codeWord = w;
    rotSel   = 3'(sel);
    wideMode = wide;
    #5;
    checkAll();
  endtask

  logic [14:0] words [6];

  initial begin
    logic [14:0] lfsr;
    words[0] = {3'd0, 3'd1, 3'd2, 3'd2, 3'd3};
    words[1] = {3'd3, 3'd2, 3'd1, 3'd0, 3'd4};
    words[2] = {3'd5, 3'd0, 3'd6, 3'd3, 3'd7};
    words[3] = {3'd1, 3'd1, 3'd1, 3'd1, 3'd2};
    lfsr = 15'h5A3C;
    for (int i = 4; i < 6; i++) begin
      repeat (7) lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
      words[i] = lfsr;
    end

    // Initial state: all-zero inputs give H on five digits, dark on three
    @(negedge clk);
    #5;
    for (int d = 0; d < 8; d++)
      checkDigit(d, (d < 5) ? 7'b0001001 : 7'b1111111, (d < 5) ? "R3" : "R5");

    // R1 / R2: each code on the leftmost word digit
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      codeWord = {3'(c), 12'd0};
      rotSel = 3'd0;
      wideMode = 1'b0;
      #5;
      case (c)
        0: checkDigit(4, 7'b0001001, "R1");
        1: checkDigit(4, 7'b0000110, "R1");
        2: checkDigit(4, 7'b1000111, "R1");
        3: checkDigit(4, 7'b1000000, "R1");
        default: checkDigit(4, 7'b1111111, "R2");
      endcase
    end

    // Full sweep in both modes
    for (int i = 0; i < 6; i++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 8; s++)
          applyVec(words[i], s, bit'(m));

    // R7: HELLO at select 4 in ring mode, spelled out
    applyVec(words[0], 4, 1'b1);
    checkDigit(7, 7'b0000110, "R7");
    checkDigit(0, 7'b0001001, "R7");

    // R4: five-digit selects 5..7 equal select 4
    applyVec(words[1], 4, 1'b0);
    begin
      logic [7:0][6:0] atFour;
      atFour = segOut;
      for (int s = 5; s < 8; s++) begin
        applyVec(words[1], s, 1'b0);
        checks++;
        if (segOut !== atFour) begin
          failures++;
          $display("FAIL R4 sel=%0d: got %h expected %h", s, segOut, atFour);
        end
      end
    end

    // R8: output follows inputs between clock edges
    @(posedge clk);
    #3;
    codeWord = words[0];
    rotSel = 3'd2;
    wideMode = 1'b1;
    #1;
    checks++;
    if (segOut[4] !== glyphRef(refCode(words[0], 2, 1'b1, 3))) begin
      failures++;
      $display("FAIL R8 no-edge update: got %b expected %b",
               segOut[4], glyphRef(refCode(words[0], 2, 1'b1, 3)));
    end
    codeWord = words[1];
    #1;
    checks++;
    if (segOut[4] !== glyphRef(refCode(words[1], 2, 1'b1, 3))) begin
      failures++;
      $display("FAIL R8 no-edge update: got %b expected %b",
               segOut[4], glyphRef(refCode(words[1], 2, 1'b1, 3)));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule